// File: doc/BRIEF.md
# Vector Rotation Engine with Latched Completion Interrupt

This block is a register-mapped coprocessor that turns vectors between a rotating two-axis frame and the stationary frame of a three-phase machine. Software loads its input operands and a control word, then writes a 12-bit rotor angle. That write both stores the angle and starts the transform. The engine looks up sine and cosine in an internal quarter-wave table and rotates the vector. Depending on direction and mode, it also applies the two-to-three-phase relations on the way in or the way out. The results are left in three result registers.

In the reverse direction the engine can take two rotating-frame inputs (d, q) or three phase inputs. In both cases it produces three phase outputs. The forward direction takes three phase inputs and returns the rotating-frame pair, and it runs only when the three-input mode bit is set. The job takes a fixed three cycles. Completion sets a result-valid status bit. If enabled, completion also raises an active-low interrupt that stays low until software reads the status register.

Data values are 12-bit two's complement with 11 fractional bits (full scale ±2047). Angles are unsigned 12-bit values spanning one revolution: 0 is 0 rad and 4096 would be 2π.

Top module: `vre_top`

## Requirements
- R1: After reset, the status register reads 0, the three result registers read 0, and `irq_n` is 1.
- R2: A write to write address 0 (angle) with the engine idle starts a job. Status bit 0 (busy) reads 1 for exactly the three cycles after the write edge, and status bit 4 (valid) reads 0 during them. Results and valid=1 appear after the third clock edge following the write edge.
- R3: Reverse two-in/three-out (control bit 9 = 0, control bit 10 = 0). The inputs are d (write address 1) and q (write address 2), at angle θ = 2π·(angle+0.5)/4096. With x = d·cosθ − q·sinθ and y = d·sinθ + q·cosθ, result 0 = x, result 1 = −x/2 + (√3/2)·y and result 2 = −x/2 − (√3/2)·y. Each result is within ±6 LSB.
- R4: Reverse three-in/three-out (bit 9 = 0, bit 10 = 1). The inputs are phases a, b, c at write addresses 1, 2, 3. The engine first forms x = a and y = (b − c)/√3, then proceeds as in R3, within ±6 LSB.
- R5: Forward (bit 9 = 1, bit 10 = 1). The engine takes a, b, c, forms x and y as in R4, then sets result 0 = x·cosθ + y·sinθ, result 1 = −x·sinθ + y·cosθ and result 2 = 0, within ±6 LSB.
- R6: An angle write with bit 9 = 1 and bit 10 = 0 starts nothing. Busy stays 0, valid keeps its value and the results are unchanged.
- R7: With control bit 0 (interrupt enable) set, completion drives `irq_n` low after the same edge that sets valid, and status bit 11 reads 1. `irq_n` stays low until a status read (read address 3). That read returns bit 11 = 1, and `irq_n` is 1 from the edge that accepts it.
- R8: With control bit 0 clear, completion leaves `irq_n` at 1 and status bit 11 at 0.
- R9: During a job, an angle write is ignored (no restart, no second job). Input writes during a job do not change its results.
- R10: The sine and cosine source covers all four quadrants by folding one quarter-wave table, so R3 holds for angles in every quadrant.
- R11: Reads of result registers (read addresses 0 to 2) do not clear a pending interrupt.

Read addresses: 0 to 2 are the results, 3 is status and 4 reads back the control word. Read data is registered and appears one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write address: 0 angle, 1-3 inputs, 4 control |
| wr_data | input | 12 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address: 0-2 results, 3 status, 4 control |
| rd_data | output | 12 | Registered read data, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low completion interrupt, latched |

## Verification
The bench drives on falling edges and samples on the next falling edge. Each read therefore returns the state just before the edge that accepted it. Status reads issued back to back after an angle write must show busy in the first three and valid in the fourth. `irq_n` is sampled at two points: two cycles after the write edge, where it must still be high, and three cycles after, where it must be low. Numeric results are read only after three idle cycles and are compared with the rotation computed in real arithmetic, with a ±6 LSB band.

// File: rtl/vre_pkg.sv
// Package: vre_pkg
// Shared widths, register addresses, bit positions, job record and the
// fixed-point helpers of the vector rotation engine.
// Assumes data words are signed with DW-1 fractional bits.
package vre_pkg;
    localparam int DW     = 12;           // data and angle width
    localparam int AW     = 3;            // register address width
    localparam int TAW    = DW - 2;       // quarter-wave table address width
    localparam int STAGES = 3;            // pipeline stages of one job
    localparam int CW     = $clog2(STAGES);

    localparam logic [AW-1:0] WA_ANGLE = 3'd0;
    localparam logic [AW-1:0] WA_IN0   = 3'd1;
    localparam logic [AW-1:0] WA_IN1   = 3'd2;
    localparam logic [AW-1:0] WA_IN2   = 3'd3;
    localparam logic [AW-1:0] WA_CTRL  = 3'd4;
    localparam logic [AW-1:0] RA_RES0  = 3'd0;
    localparam logic [AW-1:0] RA_RES1  = 3'd1;
    localparam logic [AW-1:0] RA_RES2  = 3'd2;
    localparam logic [AW-1:0] RA_STAT  = 3'd3;
    localparam logic [AW-1:0] RA_CTRL  = 3'd4;

    localparam int CB_IEN = 0;            // interrupt enable
    localparam int CB_FWD = 9;            // forward direction
    localparam int CB_TRI = 10;           // three inputs
    localparam int SB_BUSY  = 0;
    localparam int SB_VALID = 4;
    localparam int SB_IRQ   = 11;

    typedef logic signed [DW-1:0]   dat_t;
    typedef logic signed [DW:0]     ext_t;
    typedef logic signed [2*DW+1:0] wide_t;

    typedef struct packed {
        logic          fwd;
        logic          tri3;
        logic [DW-1:0] ang;
        dat_t          in0;
        dat_t          in1;
        dat_t          in2;
    } job_t;

    localparam int   K_C_I = int'(0.5773502692 * real'(2 ** (DW - 1)));
    localparam int   K_S_I = int'(0.8660254038 * real'(2 ** (DW - 1)));
    localparam ext_t K_C   = ext_t'(K_C_I);   // 1/sqrt(3)
    localparam ext_t K_S   = ext_t'(K_S_I);   // sqrt(3)/2
    localparam wide_t WMAX = wide_t'(2 ** (DW - 1) - 1);
    localparam wide_t WMIN = -WMAX - wide_t'(1);

    // Fractional product of two operands, rescaled to data units.
    function automatic wide_t mulq(input ext_t a, input ext_t b);
        wide_t p;
        p = wide_t'(a) * wide_t'(b);
        return p >>> (DW - 1);
    endfunction

    // Clamp a wide value into the data range.
    function automatic dat_t sat(input wide_t v);
        wide_t c;
        if (v > WMAX)      c = WMAX;
        else if (v < WMIN) c = WMIN;
        else               c = v;
        return c[DW-1:0];
    endfunction
endpackage

// File: rtl/vre_sincos.sv
// Module: vre_sincos
// Combinational sine and cosine of an unsigned angle. One quarter-wave
// magnitude table is built at elaboration (sampled at half-step centres)
// and folded by the two angle MSBs. Assumes angle width = table bits + 2.
module vre_sincos
    import vre_pkg::*;
#(
    parameter int AB = TAW
) (
    input  logic [AB+1:0] ang,
    output dat_t          sin_v,
    output dat_t          cos_v
);
    localparam int    NENT = 2 ** AB;
    localparam real   AMP  = real'(2 ** (AB + 1) - 1);
    localparam real   HPI  = 1.5707963267948966;

    // Magnitude of sine at the centre of table step i (series expansion).
    function automatic logic [AB:0] rom_val(input int i);
        real x, t, s;
        x = (real'(i) + 0.5) * HPI / real'(NENT);
        t = x;
        s = x;
        for (int k = 1; k < 8; k++) begin
            t = -t * x * x / real'((2 * k) * (2 * k + 1));
            s = s + t;
        end
        return (AB+1)'($rtoi(s * AMP + 0.5));
    endfunction

    logic [AB:0] rom [NENT];

    for (genvar gi = 0; gi < NENT; gi++) begin : g_rom
        localparam logic [AB:0] VAL = rom_val(gi);
        assign rom[gi] = VAL;
    end

    logic [1:0]    quad;
    logic [AB-1:0] idx;
    dat_t          mag_f, mag_r;

    assign quad  = ang[AB+1:AB];
    assign idx   = ang[AB-1:0];
    assign mag_f = dat_t'({1'b0, rom[idx]});
    assign mag_r = dat_t'({1'b0, rom[~idx]});

    // Quadrant folding of the two table reads.
    always_comb begin
        unique case (quad)
            2'd0:    begin sin_v =  mag_f; cos_v =  mag_r; end
            2'd1:    begin sin_v =  mag_r; cos_v = -mag_f; end
            2'd2:    begin sin_v = -mag_f; cos_v = -mag_r; end
            default: begin sin_v = -mag_r; cos_v =  mag_f; end
        endcase
    end
endmodule

// File: rtl/vre_seq.sv
// Module: vre_seq
// Job sequencer: accepts a start when idle, then walks a one-hot stage
// enable through STAGES cycles. Busy covers exactly those cycles.
// Assumes the requester holds its operands stable while busy.
module vre_seq
    import vre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [STAGES-1:0] stage_en
);
    logic [CW-1:0] cnt;

    assign accept = start_req && !busy;
    assign done   = stage_en[STAGES-1];

    for (genvar gs = 0; gs < STAGES; gs++) begin : g_en
        assign stage_en[gs] = busy && (cnt == CW'(gs));
    end

    // Busy flag and stage counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/vre_datapath.sv
// Module: vre_datapath
// Three registered stages: (1) table sample and input Clarke step,
// (2) rotation by +theta (reverse) or -theta (forward), (3) inverse
// Clarke (reverse) or pass-through (forward). Assumes job is stable
// while any stage enable is high.
module vre_datapath
    import vre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] stage_en,
    input  job_t              job,
    input  dat_t              sin_v,
    input  dat_t              cos_v,
    output dat_t              res0,
    output dat_t              res1,
    output dat_t              res2
);
    dat_t  s1_sin, s1_cos, s1_x, s1_y;
    dat_t  s2_x, s2_y;
    dat_t  c_y, n1_x, n1_y, n2_x, n2_y, n3_0, n3_1, n3_2;
    ext_t  bc_diff;
    wide_t xc, xs, yc, ys, half, sy;

    // Stage 1 inputs: alpha/beta from phases, or d/q directly.
    always_comb begin
        bc_diff = ext_t'(job.in1) - ext_t'(job.in2);
        c_y     = sat(mulq(bc_diff, K_C));
        n1_x    = job.in0;
        n1_y    = job.tri3 ? c_y : job.in1;
    end

    // Stage 2 inputs: rotation products and sums.
    always_comb begin
        xc = mulq(ext_t'(s1_x), ext_t'(s1_cos));
        xs = mulq(ext_t'(s1_x), ext_t'(s1_sin));
        yc = mulq(ext_t'(s1_y), ext_t'(s1_cos));
        ys = mulq(ext_t'(s1_y), ext_t'(s1_sin));
        if (job.fwd) begin
            n2_x = sat(xc + ys);
            n2_y = sat(yc - xs);
        end else begin
            n2_x = sat(xc - ys);
            n2_y = sat(xs + yc);
        end
    end

    // Stage 3 inputs: two-to-three phase expansion or pass-through.
    always_comb begin
        half = wide_t'(s2_x) >>> 1;
        sy   = mulq(ext_t'(s2_y), K_S);
        if (job.fwd) begin
            n3_0 = s2_x;
            n3_1 = s2_y;
            n3_2 = '0;
        end else begin
            n3_0 = s2_x;
            n3_1 = sat(sy - half);
            n3_2 = sat(-sy - half);
        end
    end

    // Stage 1 registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sin <= '0; s1_cos <= '0; s1_x <= '0; s1_y <= '0;
        end else if (stage_en[0]) begin
            s1_sin <= sin_v; s1_cos <= cos_v; s1_x <= n1_x; s1_y <= n1_y;
        end
    end

    // Stage 2 registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_x <= '0; s2_y <= '0;
        end else if (stage_en[1]) begin
            s2_x <= n2_x; s2_y <= n2_y;
        end
    end

    // Result registers, held until the next job ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res0 <= '0; res1 <= '0; res2 <= '0;
        end else if (stage_en[2]) begin
            res0 <= n3_0; res1 <= n3_1; res2 <= n3_2;
        end
    end
endmodule

// File: rtl/vre_top.sv
// Module: vre_top
// Register-mapped vector rotation engine. An angle write starts a job
// (unless forward with two-input mode); completion sets valid and, when
// enabled, a pending interrupt that a status read clears.
// Assumes single-cycle writes and one read per strobe.
module vre_top
    import vre_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq_n
);
    logic [DW-1:0]     ctrl_q;
    dat_t              in0_q, in1_q, in2_q;
    job_t              job_q;
    logic              start_req, accept, busy, done, res_valid, irq_pend;
    logic              stat_rd;
    logic [STAGES-1:0] stage_en;
    dat_t              sin_v, cos_v, res0, res1, res2;
    logic [DW-1:0]     stat_w, rd_next;

    assign start_req = wr_en && (wr_addr == WA_ANGLE)
                       && !(ctrl_q[CB_FWD] && !ctrl_q[CB_TRI]);
    assign stat_rd   = rd_en && (rd_addr == RA_STAT);
    assign irq_n     = !irq_pend;

    vre_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .accept(accept),
        .busy(busy), .done(done), .stage_en(stage_en)
    );

    vre_sincos u_sc (.ang(job_q.ang), .sin_v(sin_v), .cos_v(cos_v));

    vre_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .job(job_q),
        .sin_v(sin_v), .cos_v(cos_v), .res0(res0), .res1(res1), .res2(res2)
    );

    // Operand and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0; in0_q <= '0; in1_q <= '0; in2_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                WA_IN0:  in0_q  <= dat_t'(wr_data);
                WA_IN1:  in1_q  <= dat_t'(wr_data);
                WA_IN2:  in2_q  <= dat_t'(wr_data);
                WA_CTRL: ctrl_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Job snapshot taken at start; the angle comes straight from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_q <= '0;
        end else if (accept) begin
            job_q.fwd  <= ctrl_q[CB_FWD];
            job_q.tri3 <= ctrl_q[CB_TRI];
            job_q.ang  <= wr_data;
            job_q.in0  <= in0_q;
            job_q.in1  <= in1_q;
            job_q.in2  <= in2_q;
        end
    end

    // Result-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_valid <= 1'b0;
        else if (accept) res_valid <= 1'b0;
        else if (done)   res_valid <= 1'b1;
    end

    // Latched interrupt; a completion wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        irq_pend <= 1'b0;
        else if (done && ctrl_q[CB_IEN])   irq_pend <= 1'b1;
        else if (stat_rd)                  irq_pend <= 1'b0;
    end

    // Status word assembly.
    always_comb begin
        stat_w           = '0;
        stat_w[SB_BUSY]  = busy;
        stat_w[SB_VALID] = res_valid;
        stat_w[SB_IRQ]   = irq_pend;
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            RA_RES0: rd_next = res0;
            RA_RES1: rd_next = res1;
            RA_RES2: rd_next = res2;
            RA_STAT: rd_next = stat_w;
            RA_CTRL: rd_next = ctrl_q;
            default: rd_next = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/vre_chk.sv
// Module: vre_chk
// Protocol checker for vre_top, bound into every instance.
module vre_chk
    import vre_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          irq_n,
    input logic          busy,
    input logic          valid,
    input logic          ien,
    input logic          fwd,
    input logic          tri3
);
    logic wr_ang, st_rd;
    assign wr_ang = wr_en && (wr_addr == WA_ANGLE);
    assign st_rd  = rd_en && (rd_addr == RA_STAT);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ang && !busy && !(fwd && !tri3) |=> busy);                   // R2
    AST_BUSY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && $past(busy, 2) |=> !busy);               // R2
    AST_NOT_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !valid);                                               // R2
    AST_FWD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ang && !busy && fwd && !tri3 |=> !busy);                     // R6
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n && !st_rd |=> !irq_n);                                   // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(ien));                                   // R8
    AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $fell(busy));                                  // R7
endmodule

bind vre_top vre_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .irq_n(irq_n), .busy(busy),
    .valid(res_valid), .ien(ctrl_q[vre_pkg::CB_IEN]),
    .fwd(ctrl_q[vre_pkg::CB_FWD]), .tri3(ctrl_q[vre_pkg::CB_TRI])
);

// File: tb/sim_vre_top.sv
// Bench: sim_vre_top
// Directed tests for vre_top; inputs change on falling edges, outputs
// are sampled on falling edges.
module sim_vre_top;
    localparam int  CLK_PERIOD = 10;
    localparam real TWO_PI     = 6.283185307179586;
    localparam int  TOL        = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        irq_n;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    vre_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input int act, input real exp);
        int e;
        e = $rtoi(exp + ((exp < 0.0) ? -0.5 : 0.5));
        n_chk++;
        if (act > e + TOL || act < e - TOL) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, e);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 12'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = int'($signed(rd_data));
    endtask

    task automatic rd_u(input logic [2:0] a, output int v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic real theta(input int ang);
        return TWO_PI * (real'(ang) + 0.5) / 4096.0;
    endfunction

    // Reverse rotation then phase expansion, checked on three results.
    task automatic check_phases(input string req, input real x, input real y);
        int v;
        rd(3'd0, v); chk_near(req, v, x);
        rd(3'd1, v); chk_near(req, v, -x / 2.0 + 0.8660254038 * y);
        rd(3'd2, v); chk_near(req, v, -x / 2.0 - 0.8660254038 * y);
    endtask

    task automatic t_reset();
        int v;
        rd_u(3'd3, v); chk("R1 status", v, 0);
        rd(3'd0, v);   chk("R1 res0", v, 0);
        rd(3'd2, v);   chk("R1 res2", v, 0);
        chk("R1 irq_n", int'(irq_n), 1);
    endtask

    task automatic t_timing();
        int v;
        wr(3'd4, 0);
        wr(3'd1, 400); wr(3'd2, 100);
        wr(3'd0, 200);
        for (int i = 0; i < 3; i++) begin
            rd_u(3'd3, v);
            chk("R2 busy during job", v & 1, 1);
            chk("R2 valid low while busy", (v >> 4) & 1, 0);
        end
        rd_u(3'd3, v);
        chk("R2 status after job", v, 16);
    endtask

    task automatic t_rev2(input string req, input int d, input int q, input int ang);
        real c, s;
        wr(3'd4, 0);
        wr(3'd1, d); wr(3'd2, q);
        wr(3'd0, ang);
        idle(3);
        c = $cos(theta(ang)); s = $sin(theta(ang));
        check_phases(req, d * c - q * s, d * s + q * c);
    endtask

    task automatic t_rev3();
        real x, y, c, s;
        wr(3'd4, 1024);
        wr(3'd1, 700); wr(3'd2, -200); wr(3'd3, -500);
        wr(3'd0, 1000);
        idle(3);
        x = 700.0; y = 300.0 / 1.7320508076;
        c = $cos(theta(1000)); s = $sin(theta(1000));
        check_phases("R4 three-in reverse", x * c - y * s, x * s + y * c);
    endtask

    task automatic t_fwd_and_reject();
        int v, r0, r1, r2;
        real x, y, c, s;
        wr(3'd4, 1536);
        wr(3'd1, 900); wr(3'd2, -450); wr(3'd3, -300);
        wr(3'd0, 512);
        idle(3);
        x = 900.0; y = -150.0 / 1.7320508076;
        c = $cos(theta(512)); s = $sin(theta(512));
        rd(3'd0, r0); chk_near("R5 forward d", r0, x * c + y * s);
        rd(3'd1, r1); chk_near("R5 forward q", r1, -x * s + y * c);
        rd(3'd2, r2); chk("R5 forward res2", r2, 0);
        wr(3'd4, 512);
        wr(3'd1, -1000);
        wr(3'd0, 3000);
        rd_u(3'd3, v); chk("R6 rejected start status", v, 16);
        idle(3);
        rd(3'd0, v); chk("R6 res0 unchanged", v, r0);
        rd(3'd1, v); chk("R6 res1 unchanged", v, r1);
    endtask

    task automatic t_busy_writes();
        int v;
        wr(3'd4, 0);
        wr(3'd1, 1000); wr(3'd2, 0);
        wr(3'd0, 0);
        wr(3'd1, -1000);
        wr(3'd0, 2048);
        idle(1);
        rd_u(3'd3, v); chk("R9 idle after single job", v, 16);
        rd_u(3'd3, v); chk("R9 no second job", v, 16);
        rd(3'd0, v);   chk_near("R9 inputs snapshot", v, 1000.0 * $cos(theta(0)));
    endtask

    task automatic t_irq();
        int v;
        wr(3'd4, 1);
        wr(3'd1, 500); wr(3'd2, 200);
        wr(3'd0, 100);
        idle(2);
        chk("R7 irq_n high before done", int'(irq_n), 1);
        idle(1);
        chk("R7 irq_n low at done", int'(irq_n), 0);
        idle(4);
        chk("R7 irq_n held", int'(irq_n), 0);
        rd(3'd0, v);
        chk("R11 result read keeps irq", int'(irq_n), 0);
        rd_u(3'd3, v);
        chk("R7 status shows irq", (v >> 11) & 1, 1);
        chk("R7 irq_n cleared by status read", int'(irq_n), 1);
        rd_u(3'd3, v);
        chk("R7 irq bit cleared", (v >> 11) & 1, 0);
    endtask

    task automatic t_masked();
        int v;
        wr(3'd4, 0);
        wr(3'd0, 300);
        idle(5);
        chk("R8 masked irq_n", int'(irq_n), 1);
        rd_u(3'd3, v);
        chk("R8 masked status", v, 16);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_timing();
        t_rev2("R3 reverse q0", 800, -300, 300);
        t_rev2("R10 reverse q1", 800, -300, 1300);
        t_rev2("R10 reverse q2", 800, -300, 2500);
        t_rev2("R10 reverse q3", 800, -300, 3700);
        t_rev3();
        t_fwd_and_reject();
        t_busy_writes();
        t_irq();
        t_masked();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule